// File: doc/BRIEF.md
# Interrupt and BRK Bus Sequencer

This block reproduces, cycle by cycle, the bus traffic a small 8-bit processor core generates when it fetches an opcode, runs a software break, or accepts a maskable hardware interrupt. It owns the program counter, the stack pointer and a status byte. It drives a 16-bit address, a read strobe and a write enable with write data. Read data comes back from a memory whose output is valid during the same cycle as the address.

Every opcode other than the break code (0x00) is treated as a two-cycle fetch followed by the next fetch. A break and an accepted interrupt both run the same seven-cycle path: two reads, three stack writes, and two reads of the vector. On an interrupt the program counter is not advanced. The second read therefore repeats the first address, and the stacked return address points at the opcode that was displaced.

The interrupt line is active low. It is only seen at the close of an instruction's final cycle. That makes it possible to check whether a read-sensitive address is touched in an instruction's second cycle.

Top module: `irq_brk_seq`

## Requirements
- R1: Each instruction starts with an opcode read at PC, marked by `sync`, followed by a read at PC+1. A non-break opcode then starts the next fetch at PC+1.
- R2: A break or interrupt occupies exactly seven cycles: read, read, write, write, write, read of 0xFFFE, read of 0xFFFF. `rd` and `we` are never high together.
- R3: For a break at address A, the second cycle reads A+1 and the stacked return address is A+2.
- R4: For an accepted interrupt that displaces the opcode at A, both of the first two cycles read A, and the stacked return address is A.
- R5: Stack writes go to address {0x01, SP} in the order high PC byte, low PC byte, status. SP drops by one after each write, so a later break writes below the earlier one.
- R6: The stacked status byte has bit 5 set and bit 2 equal to the interrupt-disable flag before the entry. Bit 4 is 1 for a break and 0 for an interrupt.
- R7: The byte read at 0xFFFE becomes the low PC byte and the byte read at 0xFFFF becomes the high PC byte. The next opcode read uses that PC.
- R8: Both entry paths set the interrupt-disable flag, after which a held-low `irq_n` starts no further interrupt.
- R9: `irq_n` is sampled only at the clock edge that ends an instruction's last cycle. A low level present only during an opcode-read cycle lets that opcode run normally.
- R10: After reset the block is in an opcode-read cycle at PC 0x0200 with SP 0xFD and the interrupt-disable flag clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_n | input | 1 | Maskable interrupt request, active low |
| rdata | input | 8 | Read data for the current address |
| addr | output | 16 | Bus address |
| rd | output | 1 | High in every read cycle |
| we | output | 1 | High in every stack-write cycle |
| wdata | output | 8 | Data written when `we` is high |
| sync | output | 1 | High in an opcode-read cycle |

## Verification
The bus is compared against a recorded trace for four stimulus patterns, each of which separates one pair of behaviours. A plain opcode followed by a break tells the PC+1 second read and the doubly advanced return address apart from the interrupt case. An interrupt raised in the second cycle of a fetch shows the repeated address, the return address that points back, and the cleared break bit. An interrupt raised only during the next opcode read must leave that opcode untouched, which exposes a wrong sampling point. Two breaks in a row show the stack walking downward and the disable flag being set on the first entry.

// File: rtl/irq_brk_seq.sv
module irq_brk_seq #(
  parameter logic [15:0] PC_INIT  = 16'h0200,
  parameter logic [7:0]  SP_INIT  = 8'hFD,
  parameter logic [7:0]  P_INIT   = 8'h20,
  parameter logic [15:0] VEC_ADDR = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_n,
  input  logic [7:0]  rdata,
  output logic [15:0] addr,
  output logic        rd,
  output logic        we,
  output logic [7:0]  wdata,
  output logic        sync
);
  localparam logic [7:0]  STK_PAGE = 8'h01;
  localparam logic [7:0]  BRK_OP   = 8'h00;
  localparam logic [15:0] VEC_HI   = VEC_ADDR + 16'd1;
  localparam int          IBIT     = 2;

  typedef enum logic [2:0] {T1, T2, T3, T4, T5, T6, T7} cyc_t;

  cyc_t        cyc;
  logic [15:0] pc;
  logic [7:0]  sp, p;
  logic        pend, brk_seq, from_irq;

  wire take_irq = !irq_n && !p[IBIT];

  always_comb begin
    case (cyc)
      T3, T4, T5: addr = {STK_PAGE, sp};
      T6:         addr = VEC_ADDR;
      T7:         addr = VEC_HI;
      default:    addr = pc;
    endcase
    case (cyc)
      T3:      wdata = pc[15:8];
      T4:      wdata = pc[7:0];
      T5:      wdata = p | 8'h20 | (from_irq ? 8'h00 : 8'h10);
      default: wdata = 8'h00;
    endcase
  end

  assign we   = (cyc == T3) || (cyc == T4) || (cyc == T5);
  assign rd   = !we;
  assign sync = (cyc == T1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc      <= T1;
      pc       <= PC_INIT;
      sp       <= SP_INIT;
      p        <= P_INIT;
      pend     <= 1'b0;
      brk_seq  <= 1'b0;
      from_irq <= 1'b0;
    end else begin
      case (cyc)
        T1: begin
          from_irq <= pend;
          brk_seq  <= pend || (rdata == BRK_OP);
          if (!pend) pc <= pc + 16'd1;
          pend <= 1'b0;
          cyc  <= T2;
        end
        T2: begin
          if (brk_seq) begin
            if (!from_irq) pc <= pc + 16'd1;
            cyc <= T3;
          end else begin
            pend <= take_irq;
            cyc  <= T1;
          end
        end
        T3: begin sp <= sp - 8'd1; cyc <= T4; end
        T4: begin sp <= sp - 8'd1; cyc <= T5; end
        T5: begin
          sp      <= sp - 8'd1;
          p[IBIT] <= 1'b1;
          cyc     <= T6;
        end
        T6: begin pc[7:0] <= rdata; cyc <= T7; end
        default: begin
          pc[15:8] <= rdata;
          pend     <= take_irq;
          cyc      <= T1;
        end
      endcase
    end
  end
endmodule

// File: rtl/irq_brk_seq_chk.sv
module irq_brk_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        rd,
  input logic        we,
  input logic        sync
);
  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rd && we)); // R2
  AST_SYNC_IS_READ: assert property (@(posedge clk) disable iff (!rst_n) sync |-> rd); // R1
  AST_FETCH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> rd && !sync && ((addr == $past(addr)) || (addr == $past(addr) + 16'd1))); // R1
  AST_PUSH_PAGE: assert property (@(posedge clk) disable iff (!rst_n) we |-> addr[15:8] == 8'h01); // R5
  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (we && $past(we)) |-> addr == $past(addr) - 16'd1); // R5
  AST_VEC_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && $past(we)) |-> addr == 16'hFFFE); // R2
  AST_VEC_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && $past(rd) && $past(we, 2)) |-> addr == 16'hFFFF); // R2
  AST_AFTER_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && $past(rd, 2) && $past(we, 3)) |-> sync); // R7
endmodule

bind irq_brk_seq irq_brk_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .we(we), .sync(sync)
);

// File: tb/test_irq_brk_seq.sv
module test_irq_brk_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_n = 1'b1;
  logic [7:0]  rdata;
  logic [15:0] addr;
  logic        rd, we, sync;
  logic [7:0]  wdata;
  logic [15:0] brk_a = 16'h0201;
  logic [15:0] brk_b = 16'h1234;
  int          errors = 0;
  int          checks = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  irq_brk_seq i_irq_brk_seq (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .rdata(rdata),
    .addr(addr), .rd(rd), .we(we), .wdata(wdata), .sync(sync)
  );

  always_comb begin
    if (addr == 16'hFFFE)                      rdata = 8'h00;
    else if (addr == 16'hFFFF)                 rdata = 8'h03;
    else if (addr == brk_a || addr == brk_b)   rdata = 8'h00;
    else                                       rdata = 8'hEA;
  end

  // {sync, rd, we, addr, wdata}: NOP at 0200, BRK at 0201, vector 0300
  localparam logic [26:0] TRACE [11] = '{
    {3'b110, 16'h0200, 8'h00},  // R1
    {3'b010, 16'h0201, 8'h00},  // R1
    {3'b110, 16'h0201, 8'h00},  // R1
    {3'b010, 16'h0202, 8'h00},  // R3
    {3'b001, 16'h01FD, 8'h02},  // R5
    {3'b001, 16'h01FC, 8'h03},  // R3
    {3'b001, 16'h01FB, 8'h30},  // R6
    {3'b010, 16'hFFFE, 8'h00},  // R2
    {3'b010, 16'hFFFF, 8'h00},  // R2
    {3'b110, 16'h0300, 8'h00},  // R7
    {3'b010, 16'h0301, 8'h00}   // R7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input string req, input logic [2:0] ctl, input logic [15:0] a, input logic [7:0] d);
    chk(req, {29'd0, sync, rd, we}, {29'd0, ctl});
    chk(req, {16'd0, addr}, {16'd0, a});
    if (ctl[0]) chk(req, {24'd0, wdata}, {24'd0, d});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    irq_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    do_reset();
    bus("R10 reset", 3'b110, 16'h0200, 8'h00);

    // Trace table: NOP then BRK
    for (int i = 0; i < 11; i++) begin
      bus("R2 trace", TRACE[i][26:24], TRACE[i][23:8], TRACE[i][7:0]);
      step(1);
    end

    // R4 interrupt raised in T2 of the first fetch
    do_reset();
    brk_a = 16'h1234;
    step(1);
    irq_n = 1'b0;
    step(1);
    bus("R4 irq opcode read", 3'b110, 16'h0201, 8'h00);
    step(1);
    bus("R4 repeated read", 3'b010, 16'h0201, 8'h00);
    step(1);
    bus("R4 push hi", 3'b001, 16'h01FD, 8'h02);
    step(1);
    bus("R4 push lo", 3'b001, 16'h01FC, 8'h01);
    step(1);
    bus("R6 irq status", 3'b001, 16'h01FB, 8'h20);
    step(1);
    bus("R2 irq vec lo", 3'b010, 16'hFFFE, 8'h00);
    step(1);
    bus("R2 irq vec hi", 3'b010, 16'hFFFF, 8'h00);
    step(1);
    bus("R7 irq handler", 3'b110, 16'h0300, 8'h00);
    step(2);
    bus("R8 masked fetch", 3'b110, 16'h0301, 8'h00);
    step(1);
    bus("R8 masked second", 3'b010, 16'h0302, 8'h00);
    irq_n = 1'b1;

    // R9 low only during an opcode-read cycle
    do_reset();
    step(2);
    irq_n = 1'b0;
    bus("R9 fetch", 3'b110, 16'h0201, 8'h00);
    step(1);
    irq_n = 1'b1;
    bus("R9 opcode runs", 3'b010, 16'h0202, 8'h00);
    step(1);
    bus("R9 next fetch", 3'b110, 16'h0202, 8'h00);
    step(1);
    bus("R9 no repeat", 3'b010, 16'h0203, 8'h00);

    // R5 R8 two breaks: 0201 then 0300
    brk_a = 16'h0201;
    brk_b = 16'h0300;
    do_reset();
    step(9);
    bus("R3 second brk fetch", 3'b110, 16'h0300, 8'h00);
    step(1);
    bus("R3 second brk T2", 3'b010, 16'h0301, 8'h00);
    step(1);
    bus("R5 stack continues", 3'b001, 16'h01FA, 8'h03);
    step(1);
    bus("R5 stack lo", 3'b001, 16'h01F9, 8'h02);
    step(1);
    bus("R8 flag set in status", 3'b001, 16'h01F8, 8'h34);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule